// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Vector Controller

This block collects the interrupt sources of a two-channel serial controller (receive data available, transmitter empty and line break) and turns them into one interrupt request line, a six-bit shared pending register and an eight-bit modified interrupt vector. Each channel keeps its own in-service state. Receive service outranks transmit service. A transmit event that arrives while the same channel's receive interrupt is in service is held. It is presented once receive service is released.

Software-facing logic around the block reports acknowledges and reset-in-service commands as single-cycle strobes. It also drives the per-channel enables as steady configuration levels. The vector tells the interrupt handler which source and which channel to service. A mode input selects one of two bit layouts for the vector: the low layout places a three-bit source code in bits 3:1, and the high layout places the bit-reversed code in bits 6:4. Index 0 of every per-channel bus is channel B and index 1 is channel A.

Top module: `serial_irq_vec`

## Requirements
- R1: After a synchronous active-low reset, `pending` is 0x00, `irq` is 0 and `vector` shows the no-interrupt code (0x06 in low mode, 0x60 in high mode).
- R2: Pending bit positions are fixed: channel B break 0x01, transmit 0x02, receive 0x04; channel A break 0x08, transmit 0x10, receive 0x20.
- R3: A receive strobe sets that channel's receive pending bit and puts its receive interrupt in service from the next cycle. A receive acknowledge clears both, and the vector returns to no-interrupt when nothing else is in service.
- R4: A transmit strobe while that channel has no receive interrupt in service puts transmit in service. The transmit pending bit is set only if the channel's transmit enable is 1 at that moment. A transmit acknowledge clears both.
- R5: A transmit strobe while the same channel's receive interrupt is in service is held without changing `pending` or `vector`. It is presented, with pending bit and vector, in the cycle after receive service ends.
- R6: The vector shows the in-service source with the highest priority: A receive, then B receive, then A transmit, then B transmit.
- R7: In low mode (`status_hi`=0) the vector is 0x0C for A receive, 0x04 for B receive, 0x08 for A transmit, 0x00 for B transmit and 0x06 for none.
- R8: In high mode (`status_hi`=1) the vector is 0x30 for A receive, 0x20 for B receive, 0x10 for A transmit, 0x00 for B transmit and 0x60 for none.
- R9: `irq` is the OR over both channels of three terms: transmit enable with a held transmit event; a receive mode of 01 or 10 with the receive pending bit set; the break pending bit. Receive modes 00 and 11 raise no request.
- R10: A channel's break pending bit equals (break enable AND break status) as sampled at the previous clock edge.
- R11: A reset-in-service strobe ends receive service if it is active, and otherwise ends transmit service. It leaves the receive pending bit set. Ending receive service this way also presents a held transmit event.
- R12: A strobe that sets a source in the same cycle as that source's acknowledge wins: the source stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hard reset |
| status_hi | input | 1 | Vector layout select: 0 low, 1 high |
| tx_en | input | 2 | Transmit interrupt enable per channel |
| rx_mode | input | 4 | Receive interrupt mode, 2 bits per channel (bits 1:0 B, 3:2 A) |
| brk_en | input | 2 | Break interrupt enable per channel |
| brk_sts | input | 2 | Break status level per channel |
| rx_evt | input | 2 | Receive byte available strobe |
| tx_evt | input | 2 | Transmitter empty strobe |
| rx_ack | input | 2 | Receive interrupt cleared strobe |
| tx_ack | input | 2 | Transmit interrupt cleared strobe |
| ius_rst | input | 2 | Reset-highest-in-service command strobe |
| irq | output | 1 | Combined interrupt request |
| pending | output | 6 | Shared pending register |
| vector | output | 8 | Modified interrupt vector |

## Verification
A wrong in-service flag shows in `vector` in the cycle after the strobe that set or cleared it. A stuck receive in-service flag keeps the receive code on the vector and hides a held transmit event, so `pending` lacks its transmit bit after the receive acknowledge. A lost transmit hold shows one cycle after receive service ends, when neither the transmit bit nor the transmit vector appears. Priority errors show only when two channels are in service together, so the directed cases put a B receive and an A transmit in service at once.

// File: rtl/sivc_pkg.sv
// Package: shared constants, source codes and the vector layout function
// for the dual-channel serial interrupt vector controller.
// Assumes channel index 0 is channel B and index 1 is channel A.
package sivc_pkg;
    localparam int NUM_CH   = 2;
    localparam int CH_B     = 0;
    localparam int CH_A     = 1;
    localparam int SRC_PER  = 3;                 // break, transmit, receive
    localparam int PEND_W   = SRC_PER * NUM_CH;
    localparam int VEC_W    = 8;
    localparam int MODE_W   = 2;

    // Three-bit source codes; the vector layouts are built from these.
    typedef enum logic [2:0] {
        SRC_TXB  = 3'b000,
        SRC_RXB  = 3'b010,
        SRC_NONE = 3'b011,
        SRC_TXA  = 3'b100,
        SRC_RXA  = 3'b110
    } src_code_e;

    // Place a source code into the vector: low layout bits 3:1,
    // high layout bit-reversed in bits 6:4.
    function automatic logic [VEC_W-1:0] vec_encode(input src_code_e code,
                                                   input logic hi);
        logic [2:0] c;
        c = code;
        if (hi)
            return {1'b0, c[0], c[1], c[2], 4'b0000};
        else
            return {4'b0000, c, 1'b0};
    endfunction
endpackage

// File: rtl/sivc_chan.sv
// Module: per-channel interrupt source tracker.
// Holds receive pending / in-service state, a held transmit event, transmit
// in-service state and a registered break flag, and forms the channel's
// request. Assumes strobes are single-cycle and enables are steady levels.
module sivc_chan
    import sivc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic [MODE_W-1:0] rx_mode,
    input  logic              brk_en,
    input  logic              brk_sts,
    input  logic              rx_evt,
    input  logic              tx_evt,
    input  logic              rx_ack,
    input  logic              tx_ack,
    input  logic              ius_rst,
    output logic [SRC_PER-1:0] pend,     // {receive, transmit, break}
    output logic              rx_svc,
    output logic              tx_svc,
    output logic              req
);
    logic rx_pend_q, rx_svc_q, tx_hold_q, tx_shown_q, tx_svc_q, tx_bit_q, brk_q;
    logic rx_pend_d, rx_svc_d, tx_hold_d, tx_shown_d, tx_svc_d, tx_bit_d;
    logic rx_mode_on;

    // Next state: clears first, then new events, then transmit presentation.
    always_comb begin
        rx_pend_d  = rx_pend_q;
        rx_svc_d   = rx_svc_q;
        tx_hold_d  = tx_hold_q;
        tx_shown_d = tx_shown_q;
        tx_svc_d   = tx_svc_q;
        tx_bit_d   = tx_bit_q;
        if (rx_ack) begin
            rx_pend_d = 1'b0;
            rx_svc_d  = 1'b0;
        end
        if (tx_ack) begin
            tx_hold_d  = 1'b0;
            tx_shown_d = 1'b0;
            tx_svc_d   = 1'b0;
            tx_bit_d   = 1'b0;
        end
        if (ius_rst) begin
            if (rx_svc_q)
                rx_svc_d = 1'b0;
            else if (tx_svc_q)
                tx_svc_d = 1'b0;
        end
        if (rx_evt) begin
            rx_pend_d = 1'b1;
            rx_svc_d  = 1'b1;
        end
        if (tx_evt)
            tx_hold_d = 1'b1;
        if (tx_hold_d && !tx_shown_d && !rx_svc_d) begin
            tx_shown_d = 1'b1;
            tx_svc_d   = 1'b1;
            tx_bit_d   = tx_en;
        end
    end

    // State registers with synchronous hard reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_pend_q  <= 1'b0;
            rx_svc_q   <= 1'b0;
            tx_hold_q  <= 1'b0;
            tx_shown_q <= 1'b0;
            tx_svc_q   <= 1'b0;
            tx_bit_q   <= 1'b0;
            brk_q      <= 1'b0;
        end else begin
            rx_pend_q  <= rx_pend_d;
            rx_svc_q   <= rx_svc_d;
            tx_hold_q  <= tx_hold_d;
            tx_shown_q <= tx_shown_d;
            tx_svc_q   <= tx_svc_d;
            tx_bit_q   <= tx_bit_d;
            brk_q      <= brk_en & brk_sts;
        end
    end

    // Receive modes 01 and 10 allow a receive request.
    assign rx_mode_on = (rx_mode == 2'b01) || (rx_mode == 2'b10);

    // Channel request and outputs.
    assign req    = (tx_en & tx_hold_q) | (rx_mode_on & rx_pend_q) | brk_q;
    assign pend   = {rx_pend_q, tx_bit_q, brk_q};
    assign rx_svc = rx_svc_q;
    assign tx_svc = tx_svc_q;
endmodule

// File: rtl/sivc_vec_sel.sv
// Module: vector selector. Picks the highest-priority in-service source
// (A receive, B receive, A transmit, B transmit) and lays out its code
// according to the status mode. Purely combinational over registered state.
module sivc_vec_sel
    import sivc_pkg::*;
(
    input  logic [NUM_CH-1:0] rx_svc,
    input  logic [NUM_CH-1:0] tx_svc,
    input  logic              status_hi,
    output logic [VEC_W-1:0]  vector
);
    src_code_e code;

    // Priority pick: later assignments override earlier, lowest first.
    always_comb begin
        code = SRC_NONE;
        if (tx_svc[CH_B]) code = SRC_TXB;
        if (tx_svc[CH_A]) code = SRC_TXA;
        if (rx_svc[CH_B]) code = SRC_RXB;
        if (rx_svc[CH_A]) code = SRC_RXA;
    end

    // Layout of the selected code.
    assign vector = vec_encode(code, status_hi);
endmodule

// File: rtl/serial_irq_vec.sv
// Module: top of the dual-channel serial interrupt vector controller.
// Instantiates one tracker per channel, assembles the shared pending
// register, ORs the channel requests and drives the vector.
// Assumes index 0 = channel B, index 1 = channel A.
module serial_irq_vec
    import sivc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     status_hi,
    input  logic [NUM_CH-1:0]        tx_en,
    input  logic [MODE_W*NUM_CH-1:0] rx_mode,
    input  logic [NUM_CH-1:0]        brk_en,
    input  logic [NUM_CH-1:0]        brk_sts,
    input  logic [NUM_CH-1:0]        rx_evt,
    input  logic [NUM_CH-1:0]        tx_evt,
    input  logic [NUM_CH-1:0]        rx_ack,
    input  logic [NUM_CH-1:0]        tx_ack,
    input  logic [NUM_CH-1:0]        ius_rst,
    output logic                     irq,
    output logic [PEND_W-1:0]        pending,
    output logic [VEC_W-1:0]         vector
);
    logic [NUM_CH-1:0] rx_svc;
    logic [NUM_CH-1:0] tx_svc;
    logic [NUM_CH-1:0] req;

    // One source tracker per channel.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        sivc_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .tx_en   (tx_en[i]),
            .rx_mode (rx_mode[MODE_W*i +: MODE_W]),
            .brk_en  (brk_en[i]),
            .brk_sts (brk_sts[i]),
            .rx_evt  (rx_evt[i]),
            .tx_evt  (tx_evt[i]),
            .rx_ack  (rx_ack[i]),
            .tx_ack  (tx_ack[i]),
            .ius_rst (ius_rst[i]),
            .pend    (pending[SRC_PER*i +: SRC_PER]),
            .rx_svc  (rx_svc[i]),
            .tx_svc  (tx_svc[i]),
            .req     (req[i])
        );
    end

    // Combined request line.
    assign irq = |req;

    // Vector selection.
    sivc_vec_sel u_vec (
        .rx_svc    (rx_svc),
        .tx_svc    (tx_svc),
        .status_hi (status_hi),
        .vector    (vector)
    );
endmodule

// File: rtl/sivc_checker.sv
// Module: property checker for serial_irq_vec, attached by bind.
module sivc_checker
    import sivc_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic                     status_hi,
    input logic [MODE_W*NUM_CH-1:0] rx_mode,
    input logic [NUM_CH-1:0]        brk_en,
    input logic [NUM_CH-1:0]        brk_sts,
    input logic [NUM_CH-1:0]        rx_evt,
    input logic [NUM_CH-1:0]        rx_ack,
    input logic                     irq,
    input logic [PEND_W-1:0]        pending,
    input logic [VEC_W-1:0]         vector
);
    // R3: a receive strobe on A sets the A receive pending bit.
    a_r3_rx_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
        rx_evt[CH_A] |=> pending[5]);

    // R3: an acknowledge without a new strobe clears the B receive bit.
    a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ack[CH_B] && !rx_evt[CH_B]) |=> !pending[2]);

    // R6: A receive has top priority on the vector.
    a_r6_rxa_top: assert property (@(posedge clk) disable iff (!rst_n)
        rx_evt[CH_A] |=> (vector == (status_hi ? 8'h30 : 8'h0C)));

    // R9: pending A receive in mode 01 raises the request line.
    a_r9_rx_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (pending[5] && rx_mode[3:2] == 2'b01) |-> irq);

    // R10: enabled break status shows as B break pending next cycle.
    a_r10_brk: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_en[CH_B] && brk_sts[CH_B]) |=> pending[0]);

    // R7, R8: the vector always holds one of the legal codes for its layout.
    a_r7_vec_legal: assert property (@(posedge clk) disable iff (!rst_n)
        status_hi ? (vector inside {8'h60, 8'h30, 8'h20, 8'h10, 8'h00})
                  : (vector inside {8'h06, 8'h0C, 8'h04, 8'h08, 8'h00}));
endmodule

bind serial_irq_vec sivc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .status_hi (status_hi),
    .rx_mode   (rx_mode),
    .brk_en    (brk_en),
    .brk_sts   (brk_sts),
    .rx_evt    (rx_evt),
    .rx_ack    (rx_ack),
    .irq       (irq),
    .pending   (pending),
    .vector    (vector)
);

// File: tb/serial_irq_vec_test.sv
// Directed bench for serial_irq_vec. Index 0 = channel B, 1 = channel A.
module serial_irq_vec_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       status_hi = 1'b0;
    logic [1:0] tx_en = 2'b11;
    logic [3:0] rx_mode = 4'b0101;
    logic [1:0] brk_en = 2'b00;
    logic [1:0] brk_sts = 2'b00;
    logic [1:0] rx_evt = 2'b00;
    logic [1:0] tx_evt = 2'b00;
    logic [1:0] rx_ack = 2'b00;
    logic [1:0] tx_ack = 2'b00;
    logic [1:0] ius_rst = 2'b00;
    logic       irq;
    logic [5:0] pending;
    logic [7:0] vector;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    serial_irq_vec uut (
        .clk(clk), .rst_n(rst_n), .status_hi(status_hi), .tx_en(tx_en),
        .rx_mode(rx_mode), .brk_en(brk_en), .brk_sts(brk_sts),
        .rx_evt(rx_evt), .tx_evt(tx_evt), .rx_ack(rx_ack), .tx_ack(tx_ack),
        .ius_rst(ius_rst), .irq(irq), .pending(pending), .vector(vector)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // Advance one edge, then clear all strobes away from the edge.
    task automatic tick();
        @(posedge clk);
        #1;
        rx_evt = 0; tx_evt = 0; rx_ack = 0; tx_ack = 0; ius_rst = 0;
    endtask

    task automatic expect3(input string req, input logic [5:0] p,
                           input logic [7:0] v, input logic i);
        chk({req, " pending"}, {2'b00, pending}, {2'b00, p});
        chk({req, " vector"}, vector, v);
        chk({req, " irq"}, {7'd0, irq}, {7'd0, i});
    endtask

    task automatic t_reset();
        expect3("R1 reset low", 6'h00, 8'h06, 1'b0);
        status_hi = 1; #1;
        chk("R1 reset high vector", vector, 8'h60);
        status_hi = 0; #1;
    endtask

    task automatic t_rx_basic();
        rx_evt = 2'b10; tick();
        expect3("R3 R2 R7 rx A", 6'h20, 8'h0C, 1'b1);
        rx_ack = 2'b10; tick();
        expect3("R3 rx A ack", 6'h00, 8'h06, 1'b0);
        status_hi = 1;
        rx_evt = 2'b01; tick();
        expect3("R8 R2 rx B high", 6'h04, 8'h20, 1'b1);
        rx_ack = 2'b01; tick();
        expect3("R8 none high", 6'h00, 8'h60, 1'b0);
        rx_evt = 2'b10; tick();
        chk("R8 rx A high", vector, 8'h30);
        rx_ack = 2'b10; tick();
        status_hi = 0;
    endtask

    task automatic t_tx_basic();
        tx_evt = 2'b10; tick();
        expect3("R4 R2 tx A", 6'h10, 8'h08, 1'b1);
        status_hi = 1; #1;
        chk("R8 tx A high", vector, 8'h10);
        status_hi = 0;
        tx_ack = 2'b10; tick();
        expect3("R4 tx A ack", 6'h00, 8'h06, 1'b0);
        tx_en = 2'b10;
        tx_evt = 2'b01; tick();
        expect3("R4 R7 tx B disabled", 6'h00, 8'h00, 1'b0);
        tx_ack = 2'b01; tick();
        tx_en = 2'b11;
        tx_evt = 2'b01; tick();
        expect3("R2 tx B enabled", 6'h02, 8'h00, 1'b1);
        tx_ack = 2'b01; tick();
        expect3("R4 tx B ack", 6'h00, 8'h06, 1'b0);
    endtask

    task automatic t_tx_defer();
        rx_evt = 2'b10; tick();
        tx_evt = 2'b10; tick();
        expect3("R5 tx held", 6'h20, 8'h0C, 1'b1);
        rx_ack = 2'b10; tick();
        expect3("R5 tx presented", 6'h10, 8'h08, 1'b1);
        tx_ack = 2'b10; tick();
        expect3("R5 clear", 6'h00, 8'h06, 1'b0);
    endtask

    task automatic t_ius();
        rx_evt = 2'b10; tick();
        tx_evt = 2'b10; tick();
        ius_rst = 2'b10; tick();
        expect3("R11 rx service ended", 6'h30, 8'h08, 1'b1);
        ius_rst = 2'b10; tick();
        expect3("R11 tx service ended", 6'h30, 8'h06, 1'b1);
        rx_ack = 2'b10; tx_ack = 2'b10; tick();
        expect3("R11 clear", 6'h00, 8'h06, 1'b0);
    endtask

    task automatic t_prio();
        rx_evt = 2'b01; tx_evt = 2'b10; tick();
        expect3("R6 B rx over A tx", 6'h14, 8'h04, 1'b1);
        rx_ack = 2'b01; tick();
        expect3("R6 A tx after", 6'h10, 8'h08, 1'b1);
        rx_evt = 2'b10; tick();
        chk("R6 A rx over A tx", vector, 8'h0C);
        rx_ack = 2'b10; tx_ack = 2'b10; tick();
        expect3("R6 clear", 6'h00, 8'h06, 1'b0);
    endtask

    task automatic t_irq_modes();
        rx_mode = 4'b1101;
        rx_evt = 2'b10; tick();
        chk("R9 mode 11 no irq", {7'd0, irq}, 8'h00);
        chk("R9 mode 11 pending", {2'b00, pending}, 8'h20);
        rx_mode = 4'b1001; #1;
        chk("R9 mode 10 irq", {7'd0, irq}, 8'h01);
        rx_mode = 4'b0001; #1;
        chk("R9 mode 00 no irq", {7'd0, irq}, 8'h00);
        rx_mode = 4'b0101;
        rx_ack = 2'b10; tick();
    endtask

    task automatic t_break();
        brk_en = 2'b01; brk_sts = 2'b01; #1;
        chk("R10 not yet", {2'b00, pending}, 8'h00);
        tick();
        expect3("R10 B break", 6'h01, 8'h06, 1'b1);
        brk_en = 2'b00; tick();
        expect3("R10 B off", 6'h00, 8'h06, 1'b0);
        brk_en = 2'b10; brk_sts = 2'b10; tick();
        expect3("R10 A break", 6'h08, 8'h06, 1'b1);
        brk_sts = 2'b00; tick();
        chk("R10 A off", {2'b00, pending}, 8'h00);
        brk_en = 2'b00;
    endtask

    task automatic t_same_cycle();
        rx_evt = 2'b10; tick();
        rx_evt = 2'b10; rx_ack = 2'b10; tick();
        expect3("R12 event wins", 6'h20, 8'h0C, 1'b1);
        rx_ack = 2'b10; tick();
        expect3("R12 clear", 6'h00, 8'h06, 1'b0);
    endtask

    task automatic t_hard_reset();
        rx_evt = 2'b11; tx_evt = 2'b11; tick();
        rst_n = 0; tick(); rst_n = 1; #1;
        expect3("R1 hard reset", 6'h00, 8'h06, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1;
        tick();
        t_reset();
        t_rx_basic();
        t_tx_basic();
        t_tx_defer();
        t_ius();
        t_prio();
        t_irq_modes();
        t_break();
        t_same_cycle();
        t_hard_reset();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule